// File: doc/BRIEF.md
# Key-Locked Countdown Watchdog

This block is a countdown watchdog timer with a small 16-bit register file. A slow tick enable drives it; at 32768 ticks per second, a reload of 1638 expires after about 50 ms. The reload value is 32 bits wide and is written as two 16-bit halves. A control register starts the counter, picks how much of the reload value is used, and decides what happens on expiry. A lock register guards both the control register and the reload registers. Those registers only accept writes after the unlock key has been written to the lock register.

Software unlocks the block, loads the timeout, sets the run bit and locks the block again. The running watchdog is serviced by rewriting the low reload half. If the count runs out while reset-on-expiry is enabled, the block raises a system reset request, and that request stays high until the block itself is reset. If reset-on-expiry is not enabled, the block sets a sticky expired flag and starts the count over.

Top module: `keylock_wdt`

## Requirements
- R1: After a synchronous active-low reset, the reload halves and all control bits read as 0, the expired flag is 0, `rst_req` is 0, and the block is locked (lock register read returns 1).
- R2: Writing 0xE551 to the lock register (address 0x20) unlocks the block. Writing any other 16-bit value locks it. A read of address 0x20 returns 1 in bit 0 while locked and 0 while unlocked.
- R3: While locked, writes to the reload registers and the control register are ignored. Reads of these registers always return their current contents.
- R4: Register addresses are: reload low half at 0x00, reload high half at 0x04, control at 0x08. Control bit 1 is run, bit 2 is wide mode, bit 3 is reset-on-expiry, and bit 4 is the read-only expired flag. An undefined address reads 0.
- R5: A control write that changes run from 0 to 1 loads the counter from the reload value. Each later tick while running decrements it. The N-th tick after a load of N is the expiry tick. A load of 0 or 1 expires on the first tick.
- R6: With wide mode set, the reload value is {high half, low half}. With wide mode clear, the high half is ignored and only the low half is used.
- R7: On expiry with reset-on-expiry set, `rst_req` goes high at that tick's clock edge. It stays high through any later ticks or register writes until `rst_n` is asserted.
- R8: On expiry with reset-on-expiry clear, the sticky expired flag is set, `rst_req` stays low, and the counter reloads, so the next expiry comes N ticks later.
- R9: Writing the low reload half while unlocked and running reloads the counter with the new value. This is the service operation.
- R10: While run is 0, ticks have no effect, and no expiry can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable, nominally at 32768 Hz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is a wide-mode expiry where the high reload half is nonzero. To reach it, the count must cross a 16-bit boundary, which takes more than 65536 ticks. The bench loads high half 1 and low half 2 with wide mode set. It then issues one tick per clock and checks that the expired flag is still clear one tick before the 65538th tick and set after it. The same high half with wide mode clear must expire after only the low-half count. The bench proves the reload after a non-reset expiry by turning on reset-on-expiry while the counter runs. It then counts out a second full period up to the reset request.

// File: rtl/wdt_pkg.sv
// Shared constants for the key-locked watchdog: register addresses,
// control bit positions and the unlock key.
package wdt_pkg;
    parameter int ADDR_W = 6;
    parameter int HALF_W = 16;

    localparam logic [ADDR_W-1:0] ADR_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] ADR_LOCK    = 6'h20;

    localparam int BIT_RUN     = 1;
    localparam int BIT_WIDE    = 2;
    localparam int BIT_RST_EN  = 3;
    localparam int BIT_EXPIRED = 4;

    localparam logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551;
endpackage

// File: rtl/wdt_regfile.sv
// Register file and lock for the watchdog.
// Holds the reload halves, the control bits and the lock flag. Load and
// control writes are accepted only while unlocked. Issues a one-cycle
// reload pulse, registered, on a run 0->1 write or a load-low write while
// running, so the counter loads from the already-updated registers.
// Assumes a single-cycle write strobe; reads are combinational.
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = HALF_W,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          expired,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] reload_val,
    output logic          run,
    output logic          rst_en,
    output logic          reload_p
);
    logic          locked_q;
    logic [DW-1:0] lo_q, hi_q;
    logic          run_q, wide_q, rsten_q, reload_q;
    logic          open_wr;
    logic          unused_wdata;

    assign open_wr      = wr_en && !locked_q;
    assign unused_wdata = ^{wdata[DW-1:BIT_RST_EN+1], wdata[0]};

    // Register writes, lock tracking and reload pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
            lo_q     <= '0;
            hi_q     <= '0;
            run_q    <= 1'b0;
            wide_q   <= 1'b0;
            rsten_q  <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            reload_q <= 1'b0;
            if (wr_en && addr == ADR_LOCK)
                locked_q <= (wdata != UNLOCK_KEY);
            if (open_wr) begin
                case (addr)
                    ADR_LOAD_LO: begin
                        lo_q <= wdata;
                        if (run_q) reload_q <= 1'b1;
                    end
                    ADR_LOAD_HI: hi_q <= wdata;
                    ADR_CTRL: begin
                        run_q   <= wdata[BIT_RUN];
                        wide_q  <= wdata[BIT_WIDE];
                        rsten_q <= wdata[BIT_RST_EN];
                        if (wdata[BIT_RUN] && !run_q) reload_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_LOAD_LO: rdata = lo_q;
            ADR_LOAD_HI: rdata = hi_q;
            ADR_CTRL: begin
                rdata[BIT_RUN]     = run_q;
                rdata[BIT_WIDE]    = wide_q;
                rdata[BIT_RST_EN]  = rsten_q;
                rdata[BIT_EXPIRED] = expired;
            end
            ADR_LOCK: rdata[0] = locked_q;
            default: rdata = '0;
        endcase
    end

    // Reload value selection by width mode.
    assign reload_val = wide_q ? {hi_q, lo_q} : {{DW{1'b0}}, lo_q};
    assign run        = run_q;
    assign rst_en     = rsten_q;
    assign reload_p   = reload_q;

    a_r3_locked_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked_q && addr == ADR_LOAD_LO) |=> $stable(lo_q));
    a_r3_locked_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked_q && addr == ADR_CTRL) |=> ($stable(run_q) && $stable(rsten_q)));
    a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_LOCK && wdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/wdt_counter.sv
// Countdown core. Loads on the reload pulse, decrements on each tick while
// running, and flags expiry on the tick taken at a count of 1 or 0. After
// a reset-enabled expiry it holds at zero; otherwise it reloads.
// Assumes reload_val is stable in the cycle that reload_p is high.
module wdt_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run,
    input  logic          rst_en,
    input  logic          reload_p,
    input  logic [CW-1:0] reload_val,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = run && tick_en && !reload_p && (cnt_q <= CW'(1));

    // Count, reload and hold behaviour.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload_p)
            cnt_q <= reload_val;
        else if (expire)
            cnt_q <= rst_en ? '0 : reload_val;
        else if (run && tick_en)
            cnt_q <= cnt_q - CW'(1);
    end

    a_r5_load_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reload_p |=> (cnt_q == $past(reload_val)));
    a_r10_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_p) |=> $stable(cnt_q));
    a_r10_no_expire_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !expire);
endmodule

// File: rtl/wdt_expiry.sv
// Expiry handling: turns an expiry event into either the sticky reset
// request or the sticky expired flag, chosen by reset-on-expiry.
// Both flags clear only on the block reset.
module wdt_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rst_en,
    output logic rst_req,
    output logic expired
);
    // Sticky flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            expired <= 1'b0;
        end else if (expire) begin
            if (rst_en) rst_req <= 1'b1;
            else        expired <= 1'b1;
        end
    end

    a_r7_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    a_r7_req_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rst_en) |=> rst_req);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
    a_r8_no_req_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !rst_en && !rst_req) |=> !rst_req);
endmodule

// File: rtl/keylock_wdt.sv
// Top of the key-locked countdown watchdog: register file with key lock,
// countdown core and expiry handling.
// Assumes tick_en is a single-cycle enable synchronous to clk.
module keylock_wdt
    import wdt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = HALF_W,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req
);
    logic [CW-1:0] reload_val;
    logic          run, rst_en, reload_p, expire, expired;

    wdt_regfile #(.AW(AW), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .expired(expired), .rdata(bus_rdata),
        .reload_val(reload_val), .run(run), .rst_en(rst_en),
        .reload_p(reload_p)
    );

    wdt_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
        .rst_en(rst_en), .reload_p(reload_p), .reload_val(reload_val),
        .expire(expire)
    );

    wdt_expiry exp_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(rst_en),
        .rst_req(rst_req), .expired(expired)
    );
endmodule

// File: tb/keylock_wdt_tb_top.sv
// Directed bench for keylock_wdt: one task per scenario.
module keylock_wdt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CTRL = 6'h08, A_LOCK = 6'h20;
    localparam logic [15:0] KEY = 16'hE551;
    // control values: run=bit1, wide=bit2, reset-on-expiry=bit3
    localparam logic [15:0] C_RUN = 16'h0002, C_WIDE = 16'h0004, C_RSTEN = 16'h0008;

    always #4 clk = ~clk;

    keylock_wdt dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic expect_reg(input logic [5:0] a, input logic [15:0] e, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_reg(A_LO, 16'h0, "R1 load low");
        expect_reg(A_HI, 16'h0, "R1 load high");
        expect_reg(A_CTRL, 16'h0, "R1 ctrl");
        expect_reg(A_LOCK, 16'h1, "R1 locked");
        check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
        expect_reg(6'h10, 16'h0, "R4 undefined addr");
    endtask

    task automatic t_lock();
        do_reset();
        wr(A_LO, 16'h1234); wr(A_CTRL, C_RUN);
        expect_reg(A_LO, 16'h0, "R3 locked load write");
        expect_reg(A_CTRL, 16'h0, "R3 locked ctrl write");
        wr(A_LOCK, KEY);
        expect_reg(A_LOCK, 16'h0, "R2 unlocked");
        wr(A_LO, 16'h1234); wr(A_HI, 16'hBEEF); wr(A_CTRL, C_WIDE);
        expect_reg(A_LO, 16'h1234, "R4 load low");
        expect_reg(A_HI, 16'hBEEF, "R4 load high");
        expect_reg(A_CTRL, C_WIDE, "R4 ctrl");
        wr(A_LOCK, ~KEY);
        expect_reg(A_LOCK, 16'h1, "R2 relocked");
        wr(A_LO, 16'h5555);
        expect_reg(A_LO, 16'h1234, "R3 write after relock");
        expect_reg(A_HI, 16'hBEEF, "R3 read while locked");
    endtask

    task automatic t_narrow_expiry();
        do_reset();
        wr(A_LOCK, KEY); wr(A_HI, 16'h0001); wr(A_LO, 16'd3); wr(A_CTRL, C_RUN);
        ticks(2);
        expect_reg(A_CTRL, C_RUN, "R5 before expiry");
        ticks(1);
        expect_reg(A_CTRL, C_RUN | 16'h0010, "R6 narrow mode ignores high half");
        check(rst_req == 1'b0, "R8 no reset request", rst_req, 0);
        // R8: enable reset on expiry without reloading; next expiry 3 ticks later
        wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(2);
        check(rst_req == 1'b0, "R8 reloaded count not yet done", rst_req, 0);
        ticks(1);
        check(rst_req == 1'b1, "R8 second period expiry", rst_req, 1);
    endtask

    task automatic t_wide_expiry();
        do_reset();
        wr(A_LOCK, KEY); wr(A_HI, 16'h0001); wr(A_LO, 16'd2); wr(A_CTRL, C_RUN | C_WIDE);
        ticks(65537);
        expect_reg(A_CTRL, C_RUN | C_WIDE, "R6 wide count not done");
        ticks(1);
        expect_reg(A_CTRL, C_RUN | C_WIDE | 16'h0010, "R6 wide expiry");
    endtask

    task automatic t_reset_req();
        do_reset();
        wr(A_LOCK, KEY); wr(A_LO, 16'd4); wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(3);
        check(rst_req == 1'b0, "R7 before expiry", rst_req, 0);
        ticks(1);
        check(rst_req == 1'b1, "R7 request raised", rst_req, 1);
        ticks(5); wr(A_CTRL, 16'h0); wr(A_LOCK, 16'h0);
        check(rst_req == 1'b1, "R7 request held", rst_req, 1);
        expect_reg(A_CTRL, 16'h0, "R7 expired flag unused with reset enabled");
        do_reset();
        check(rst_req == 1'b0, "R7 cleared by reset", rst_req, 0);
    endtask

    task automatic t_zero_load();
        do_reset();
        wr(A_LOCK, KEY); wr(A_LO, 16'd0); wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(1);
        check(rst_req == 1'b1, "R5 load of 0 expires on first tick", rst_req, 1);
    endtask

    task automatic t_kick();
        do_reset();
        wr(A_LOCK, KEY); wr(A_LO, 16'd5); wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(3);
        wr(A_LO, 16'd5);
        ticks(4);
        check(rst_req == 1'b0, "R9 service restarted count", rst_req, 0);
        ticks(1);
        check(rst_req == 1'b1, "R9 expiry after service", rst_req, 1);
    endtask

    task automatic t_stopped();
        do_reset();
        wr(A_LOCK, KEY); wr(A_LO, 16'd5); wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(2);
        wr(A_CTRL, C_RSTEN);
        ticks(10);
        check(rst_req == 1'b0, "R10 ticks ignored while stopped", rst_req, 0);
        wr(A_CTRL, C_RUN | C_RSTEN);
        ticks(4);
        check(rst_req == 1'b0, "R5 rearm reloads full count", rst_req, 0);
        ticks(1);
        check(rst_req == 1'b1, "R5 rearm expiry", rst_req, 1);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_narrow_expiry();
        t_reset_req();
        t_zero_load();
        t_kick();
        t_stopped();
        t_wide_expiry();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule